// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the eight-bit condition and system status word of a small eight-bit processor datapath. Four arithmetic flags (carry, half carry, zero and overflow) are recomputed each cycle from the ALU operation class, its two operands and its result. Two system flags, power-down and watchdog time-out, are changed only by the halt, clear-watchdog and watchdog time-out strobes and by reset. The ALU and the watchdog counter live elsewhere.

The block derives the carry, half carry and overflow flags itself, with its own carry chain over the operands. The result supplied by the ALU is used only for the zero test. Subtraction follows the no-borrow convention: a set carry means that no borrow occurred. An instruction that writes the status word directly can change the four arithmetic flags. It can never change the two system flags. Reset stands for power-up and clears the whole word.

Top module: `status_flag_reg`

## Requirements
- R1: After reset `status_q` is 0. Bits 7 and 6 always read 0. The layout is C=bit0, AC=bit1, Z=bit2, OV=bit3, PDF=bit4 and TO=bit5.
- R2: The `op` encoding is 0 idle, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-carry, 5 logic, 6 rotate-left-through-carry and 7 rotate-right-through-carry. Add uses a carry-in of 0 and add-with-carry uses the current C. C takes the carry out of bit 7. AC takes the carry out of bit 3.
- R3: Subtract computes a + ~b + 1, and subtract-with-carry computes a + ~b + C. C is 1 when no borrow occurs. AC is 1 when the low nibble needs no borrow.
- R4: For the four arithmetic classes, OV is the carry into bit 7 XOR the carry out of bit 7.
- R5: For the arithmetic and logic classes, Z is 1 exactly when `res` is zero. A logic operation leaves C, AC and OV unchanged.
- R6: Rotate-left-through-carry loads C with `a[7]`. Rotate-right-through-carry loads C with `a[0]`. AC, Z and OV are unchanged by either rotate.
- R7: With `wr_en` high, bits 3..0 take `wr_data[3:0]` one cycle later, and this overrides any ALU update in the same cycle. A write never changes TO or PDF.
- R8: `halt` sets PDF. `clr_wdt` clears PDF. When both are high, halt wins.
- R9: `wdt_to` sets TO. `clr_wdt` or `halt` clears TO. A time-out in the same cycle as a clear or a halt wins.
- R10: When `op` is idle and no write or event is present, the whole word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| op | input | 3 | ALU operation class |
| a | input | DW | First ALU operand |
| b | input | DW | Second ALU operand |
| res | input | DW | ALU result, used for the zero flag |
| wr_en | input | 1 | Direct write of the status word |
| wr_data | input | 8 | Data for the direct write |
| wdt_to | input | 1 | Watchdog time-out strobe |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| status_q | output | 8 | Registered status word |

## Verification
Random operands run through all eight operation classes. The bench also forces the zero result often enough to exercise both values of Z. The directed patterns are chosen so that each flag can only come out right for one reason:
- 0x0F+0x01 separates the half carry from the full carry.
- 0x7F+0x01 and 0x80+0xFF separate overflow from carry.
- Equal-operand and 0-1 subtractions pin down the no-borrow sense of C and AC.
- Subtract-with-carry and add-with-carry, each run with both values of C, show that the carry-in comes from the stored flag.

Strobes that collide (a time-out with a halt, a write with an ALU operation) show the priority order of the two system flags and of the direct write.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [2:0] {
    OPC_IDLE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ADC   = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_SBC   = 3'd4,
    OPC_LOGIC = 3'd5,
    OPC_RLC   = 3'd6,
    OPC_RRC   = 3'd7
  } op_class_e;

  localparam int BIT_C   = 0;
  localparam int BIT_AC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_OV  = 3;
  localparam int BIT_PDF = 4;
  localparam int BIT_TO  = 5;
  localparam int SW      = 8;
  localparam int AFW     = 4;

  typedef struct packed {
    logic ov;
    logic z;
    logic ac;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/status_arith.sv
module status_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic          co,
  output logic          hc,
  output logic          ovf
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] bx;
  logic [DW:0]   cy;

  assign bx    = sub ? ~b : b;
  assign cy[0] = cin;

  for (genvar i = 0; i < DW; i++) begin : g_chain
    assign cy[i+1] = (a[i] & bx[i]) | ((a[i] ^ bx[i]) & cy[i]);
  end

  assign co  = cy[DW];
  assign hc  = cy[HALF];
  assign ovf = cy[DW] ^ cy[DW-1];
endmodule

// File: rtl/status_alu_flags.sv
module status_alu_flags
  import status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] res,
  input  arith_flags_t  cur,
  output arith_flags_t  nxt
);
  op_class_e opc;
  logic      sub, cin, co, hc, ovf, zr;

  assign opc = op_class_e'(op);
  assign sub = (opc == OPC_SUB) || (opc == OPC_SBC);
  assign zr  = (res == '0);

  always_comb begin
    unique case (opc)
      OPC_ADD:          cin = 1'b0;
      OPC_SUB:          cin = 1'b1;
      OPC_ADC, OPC_SBC: cin = cur.c;
      default:          cin = 1'b0;
    endcase
  end

  status_arith #(.DW(DW)) u_arith (
    .a   (a),
    .b   (b),
    .sub (sub),
    .cin (cin),
    .co  (co),
    .hc  (hc),
    .ovf (ovf)
  );

  always_comb begin
    nxt = cur;
    unique case (opc)
      OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBC: begin
        nxt.c  = co;
        nxt.ac = hc;
        nxt.ov = ovf;
        nxt.z  = zr;
      end
      OPC_LOGIC: nxt.z = zr;
      OPC_RLC:   nxt.c = a[DW-1];
      OPC_RRC:   nxt.c = a[0];
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/status_sys_flags.sv
module status_sys_flags (
  input  logic clk,
  input  logic rst,
  input  logic wdt_to,
  input  logic clr_wdt,
  input  logic halt,
  output logic to_q,
  output logic pdf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b0;
    end else begin
      if (wdt_to)
        to_q <= 1'b1;
      else if (clr_wdt || halt)
        to_q <= 1'b0;

      if (halt)
        pdf_q <= 1'b1;
      else if (clr_wdt)
        pdf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] res,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          wdt_to,
  input  logic          clr_wdt,
  input  logic          halt,
  output logic [7:0]    status_q
);
  arith_flags_t af_q, af_nxt;
  logic         to_q, pdf_q;

  status_alu_flags #(.DW(DW)) u_alu (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (res),
    .cur (af_q),
    .nxt (af_nxt)
  );

  status_sys_flags u_sys (
    .clk     (clk),
    .rst     (rst),
    .wdt_to  (wdt_to),
    .clr_wdt (clr_wdt),
    .halt    (halt),
    .to_q    (to_q),
    .pdf_q   (pdf_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      af_q <= '0;
    else if (wr_en)
      af_q <= arith_flags_t'(wr_data[AFW-1:0]);
    else
      af_q <= af_nxt;
  end

  always_comb begin
    status_q          = '0;
    status_q[BIT_C]   = af_q.c;
    status_q[BIT_AC]  = af_q.ac;
    status_q[BIT_Z]   = af_q.z;
    status_q[BIT_OV]  = af_q.ov;
    status_q[BIT_PDF] = pdf_q;
    status_q[BIT_TO]  = to_q;
  end
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [DW-1:0] res,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          wdt_to,
  input logic          clr_wdt,
  input logic          halt,
  input logic [7:0]    status_q
);
  logic [DW:0] add_sum;
  logic        no_evt;
  assign add_sum = {1'b0, a} + {1'b0, b};
  assign no_evt  = !wdt_to && !clr_wdt && !halt;

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
    status_q[7:6] == 2'b00);

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && !wr_en) |=> status_q[0] == $past(add_sum[DW]));

  assert_logic_only_z_R5: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5 && !wr_en) |=> (status_q[2] == ($past(res) == '0)) &&
      $stable(status_q[0]) && $stable(status_q[1]) && $stable(status_q[3]));

  assert_rotate_left_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6 && !wr_en) |=> status_q[0] == $past(a[DW-1]) &&
      $stable(status_q[3:1]));

  assert_write_low_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status_q[3:0] == $past(wr_data[3:0]));

  assert_write_keeps_sys_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && no_evt) |=> $stable(status_q[5:4]));

  assert_halt_sets_pdf_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> status_q[4]);

  assert_clr_clears_pdf_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt && !halt) |=> !status_q[4]);

  assert_timeout_sets_to_R9: assert property (@(posedge clk) disable iff (rst)
    wdt_to |=> status_q[5]);

  assert_clear_to_R9: assert property (@(posedge clk) disable iff (rst)
    ((clr_wdt || halt) && !wdt_to) |=> !status_q[5]);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 && !wr_en && no_evt) |=> $stable(status_q));
endmodule

bind status_flag_reg status_flag_reg_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op       (op),
  .a        (a),
  .b        (b),
  .res      (res),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wdt_to   (wdt_to),
  .clr_wdt  (clr_wdt),
  .halt     (halt),
  .status_q (status_q)
);

// File: tb/status_flag_reg_test.sv
`timescale 1ns/1ps
module status_flag_reg_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op;
  logic [7:0] a, b, res, wr_data;
  logic       wr_en, wdt_to, clr_wdt, halt;
  logic [7:0] status_q;
  logic [7:0] exp_q;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  status_flag_reg #(.DW(8)) uut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .res(res),
    .wr_en(wr_en), .wr_data(wr_data), .wdt_to(wdt_to),
    .clr_wdt(clr_wdt), .halt(halt), .status_q(status_q)
  );

  function automatic logic [7:0] model(input logic [7:0] q, input logic [2:0] o,
      input logic [7:0] x, input logic [7:0] y, input logic [7:0] r,
      input logic we, input logic [7:0] wd, input logic t, input logic cw,
      input logic h);
    logic [7:0] n;
    int bb, ci, s, lo;
    n = q;
    if (o >= 3'd1 && o <= 3'd4) begin
      bb = (o >= 3'd3) ? (~y & 8'hFF) : y;
      ci = (o == 3'd1) ? 0 : (o == 3'd3) ? 1 : q[0];
      s  = x + bb + ci;
      lo = (x & 15) + (bb & 15) + ci;
      n[0] = s[8];
      n[1] = lo[4];
      n[2] = (r == 8'h00);
      n[3] = (x[7] == bb[7]) && (s[7] != x[7]);
    end else if (o == 3'd5) n[2] = (r == 8'h00);
    else if (o == 3'd6) n[0] = x[7];
    else if (o == 3'd7) n[0] = x[0];
    if (we) n[3:0] = wd[3:0];
    if (t) n[5] = 1'b1; else if (cw || h) n[5] = 1'b0;
    if (h) n[4] = 1'b1; else if (cw) n[4] = 1'b0;
    n[7:6] = 2'b00;
    return n;
  endfunction

  task automatic check(input string req);
    n_run++;
    if (status_q !== exp_q) begin
      n_fail++;
      $display("FAIL %s: status_q=%02h expected %02h", req, status_q, exp_q);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
      input logic [7:0] r, input logic we, input logic [7:0] wd,
      input logic t, input logic cw, input logic h, input string req);
    op = o; a = x; b = y; res = r; wr_en = we; wr_data = wd;
    wdt_to = t; clr_wdt = cw; halt = h;
    @(posedge clk);
    exp_q = model(exp_q, o, x, y, r, we, wd, t, cw, h);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, status_q=%02h expected finish", status_q);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op = 3'd0; a = 0; b = 0; res = 0; wr_en = 0; wr_data = 0;
    wdt_to = 0; clr_wdt = 0; halt = 0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_q = 8'h00;
    check("R1 reset");
    rst = 1'b0;

    step(3'd1, 8'h0F, 8'h01, 8'h10, 0, 0, 0, 0, 0, "R2 half carry only");
    step(3'd1, 8'hFF, 8'h01, 8'h00, 0, 0, 0, 0, 0, "R2 carry and zero");
    step(3'd2, 8'h00, 8'h00, 8'h01, 0, 0, 0, 0, 0, "R2 adc uses stored C");
    step(3'd1, 8'h7F, 8'h01, 8'h80, 0, 0, 0, 0, 0, "R4 positive overflow");
    step(3'd1, 8'h80, 8'hFF, 8'h7F, 0, 0, 0, 0, 0, "R4 negative overflow");
    step(3'd3, 8'h55, 8'h55, 8'h00, 0, 0, 0, 0, 0, "R3 equal no borrow");
    step(3'd3, 8'h00, 8'h01, 8'hFF, 0, 0, 0, 0, 0, "R3 borrow clears C");
    step(3'd4, 8'h10, 8'h0F, 8'h00, 0, 0, 0, 0, 0, "R3 sbc with C=0");
    step(3'd5, 8'hAA, 8'h55, 8'h00, 0, 0, 0, 0, 0, "R5 logic zero only");
    step(3'd6, 8'h80, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R6 rotate left carry");
    step(3'd7, 8'hFE, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R6 rotate right carry");
    step(3'd1, 8'hFF, 8'h01, 8'h00, 1, 8'hF5, 0, 0, 0, "R7 write beats alu");
    step(3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 1, 0, 1, "R9 timeout beats halt");
    step(3'd0, 8'h00, 8'h00, 8'h00, 1, 8'h00, 0, 0, 0, "R7 write keeps TO PDF");
    step(3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 1, 1, "R8 halt beats clear");
    step(3'd0, 8'h12, 8'h34, 8'h00, 0, 0, 0, 0, 0, "R10 idle holds");
    step(3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 1, 0, "R8 R9 clear watchdog");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ro;
      logic [7:0] ra, rb, rr;
      ro = 3'($urandom % 8);
      ra = 8'($urandom); rb = 8'($urandom);
      rr = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      step(ro, ra, rb, rr, ($urandom % 8) == 0, 8'($urandom),
           ($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule